// File: doc/BRIEF.md
# Coded Programmable Clock Divider

This block turns a fast source clock into a slower square wave. It divides by a ratio that a 7-bit code selects. The result leaves the block as a true and complement output pair. The source is normally the oscillator clock. When the bypass select is high, the reference clock is divided instead. The source may only be switched while reset is held.

The code is not a plain binary ratio:

- The three lowest codes all give a ratio of two.
- The next three codes give ratios of three, four and five.
- Every higher code ignores its least significant bit, so the ratios run in even steps from six to 126.

Odd ratios use a helper register clocked on the falling edge, which keeps the high time at half the output period. A new code is taken only when the internal count wraps. The output period in progress therefore always finishes at the old ratio.

A low enable forces the true output low and the complement output high. Reset is synchronous and active low. It parks the output low and preloads the counter, so the first output high phase begins on the first source edge after release.

Top module: `coded_clk_divider`

## Requirements
- R1: Codes 0, 1 and 2 each divide the selected source clock by two.
- R2: Codes 3, 4 and 5 divide the selected source clock by three, four and five respectively.
- R3: For codes 6 to 127, bit 0 of the code has no effect and the ratio is the code with bit 0 cleared (even ratios 6 to 126).
- R4: For even ratios, `out_p` is high for exactly half the output period, and its rising edge follows a rising source edge.
- R5: For odd ratios, `out_p` is high for ratio/2 source periods, which is exactly half the output period; the helper register clocked on the falling edge provides the half-cycle step.
- R6: A code change takes effect only at the end of the output period in progress. That period completes at the old ratio, and the following period uses the new one. This holds even when the change lands just before the terminal edge.
- R7: While `rst_n` is low at a rising source edge, `out_p` is low and `out_n` is high. After release with an even ratio, `out_p` rises at the first rising source edge.
- R8: When `out_en` is sampled low at a rising source edge, `out_p` is held low and `out_n` is held high from that edge onward. When `out_en` is set high again, the divided clock resumes.
- R9: `out_n` is always the logical inverse of `out_p`.
- R10: With `use_ref` high (changed only while reset is held), the divider counts `clk_ref` instead of `clk_vco`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_vco | input | 1 | Oscillator clock, divided when `use_ref` is low |
| clk_ref | input | 1 | Reference clock, divided when `use_ref` is high |
| use_ref | input | 1 | Source select: 1 selects the reference clock (bypass) |
| rst_n | input | 1 | Synchronous active-low reset on the selected source |
| div_code | input | 7 | Ratio code (see R1 to R3) |
| out_en | input | 1 | Output enable, 1 = running, 0 = forced to fixed polarity |
| out_p | output | 1 | Divided clock, true phase |
| out_n | output | 1 | Divided clock, complement phase |

## Verification
The collision that matters is a code update and the counter wrap on the same source edge. The same edge both ends the old period and loads the new ratio, so an update written one half-nanosecond before the terminal edge must already shape the next period.

The bench provokes this twice:

- It changes the code in the middle of a divide-by-ten period.
- It changes the code just before the terminal edge of a divide-by-four period.

Each case is judged by timing the rising-edge spacing of `out_p`. The period that contains the change must keep the old length, and the period after it must have the new length. A late update must not bleed into the count that is still running.

// File: rtl/odiv_pkg.sv
// Shared definitions for the coded clock divider.
// Assumes: code and ratio share one width; ratio fits in that width.
package odiv_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int ODIV_CODE_W = 7;

    // Duty shaping mode picked per ratio.
    typedef enum logic {
        DUTY_EVEN = 1'b0,
        DUTY_ODD  = 1'b1
    } duty_e;
endpackage

// File: rtl/odiv_code_map.sv
// Maps the non-linear ratio code to a divide ratio, a high-phase length
// (in source cycles) and a duty mode.
// Assumes: CODE_W >= 3, purely combinational.
module odiv_code_map
    import odiv_pkg::*;
#(
    parameter int CODE_W = ODIV_CODE_W
) (
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] ratio,
    output logic [CODE_W-1:0] hi_len,
    output duty_e             duty
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [CODE_W-1:0] MIN_RATIO = CODE_W'(2);
    localparam logic [CODE_W-1:0] LAST_LIN  = CODE_W'(5);

    // Decode the code into a ratio; low codes clamp, high codes drop bit 0.
    always_comb begin
        if (code <= MIN_RATIO) begin
            ratio = MIN_RATIO;
        end else if (code <= LAST_LIN) begin
            ratio = code;
        end else begin
            ratio = {code[CODE_W-1:1], 1'b0};
        end
    end

    // Pick duty mode and the rising-edge count of the high phase.
    always_comb begin
        duty   = ratio[0] ? DUTY_ODD : DUTY_EVEN;
        hi_len = (ratio >> 1) + CODE_W'(ratio[0]);
    end

    // Range guards on the decoded ratio.
    always_comb begin
        if (!$isunknown(code)) begin
            p_ratio_floor_r1: assert (ratio >= MIN_RATIO)
                else $error("ratio below two");
            p_even_high_r3: assert (!(code > LAST_LIN) || (!ratio[0] && ratio > LAST_LIN))
                else $error("high code produced odd or small ratio");
        end
    end
endmodule

// File: rtl/odiv_counter.sv
// Period counter. Counts 0..ratio-1 and produces the high phase.
// A new ratio is taken only on wrap so no runt period appears.
// Assumes: synchronous active-low reset on the divided source clock.
module odiv_counter
    import odiv_pkg::*;
#(
    parameter int W = ODIV_CODE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ratio_in,
    input  logic [W-1:0] hi_in,
    input  duty_e        duty_in,
    output logic         hi_q,
    output duty_e        duty_q
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [W-1:0] cnt_q;
    logic [W-1:0] ratio_q;
    logic [W-1:0] hi_len_q;
    logic         wrap;

    // Terminal count of the active ratio.
    always_comb wrap = (cnt_q == ratio_q - W'(1));

    // Count, reload settings on wrap, and form the high phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= ratio_in - W'(1);
            ratio_q  <= ratio_in;
            hi_len_q <= hi_in;
            duty_q   <= duty_in;
            hi_q     <= 1'b0;
        end else if (wrap) begin
            cnt_q    <= '0;
            ratio_q  <= ratio_in;
            hi_len_q <= hi_in;
            duty_q   <= duty_in;
            hi_q     <= 1'b1;
        end else begin
            cnt_q    <= cnt_q + W'(1);
            hi_q     <= (cnt_q + W'(1)) < hi_len_q;
        end
    end

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < ratio_q)
        else $error("count beyond ratio");

    p_ratio_wrap_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ratio_q != $past(ratio_q)) |-> ($past(cnt_q) == $past(ratio_q) - W'(1)))
        else $error("ratio changed mid period");

    p_rise_at_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(hi_q)) |-> (cnt_q == '0))
        else $error("high phase began off the wrap");

    p_reset_low_r7: assert property (@(posedge clk)
        !rst_n |=> !hi_q)
        else $error("high phase during reset");
endmodule

// File: rtl/odiv_out_stage.sv
// Output stage: falling-edge helper for odd ratios, enable gating,
// and the complementary pair.
// Assumes: hi_q and duty_q come from the rising-edge counter domain.
module odiv_out_stage
    import odiv_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hi_q,
    input  duty_e duty_q,
    input  logic  en_in,
    output logic  out_p,
    output logic  out_n
);
    timeunit 1ns;
    timeprecision 1ps;

    logic neg_q;
    logic en_q;
    logic shaped;

    // Half-cycle delayed copy of the high phase for odd ratios.
    always_ff @(negedge clk) begin
        neg_q <= rst_n ? hi_q : 1'b0;
    end

    // Sample the output enable on the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_in;
    end

    // Trim the odd high phase by half a cycle, then gate and split.
    always_comb begin
        shaped = (duty_q == DUTY_ODD) ? (hi_q & neg_q) : hi_q;
        out_p  = en_q & shaped;
        out_n  = ~out_p;
    end

    p_disable_park_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_in |=> (!out_p && out_n))
        else $error("output not parked while disabled");
endmodule

// File: rtl/coded_clk_divider.sv
// Top: source select, code map, period counter and output stage.
// Assumes: use_ref changes only while rst_n is held low.
module coded_clk_divider
    import odiv_pkg::*;
(
    input  logic       clk_vco,
    input  logic       clk_ref,
    input  logic       use_ref,
    input  logic       rst_n,
    input  logic [6:0] div_code,
    input  logic       out_en,
    output logic       out_p,
    output logic       out_n
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CW = ODIV_CODE_W;

    logic          div_clk;
    logic [CW-1:0] ratio;
    logic [CW-1:0] hi_len;
    duty_e         duty;
    logic          hi_q;
    duty_e         duty_q;

    // Source select; bypass divides the reference clock.
    always_comb div_clk = use_ref ? clk_ref : clk_vco;

    odiv_code_map #(.CODE_W(CW)) u_map (
        .code   (div_code),
        .ratio  (ratio),
        .hi_len (hi_len),
        .duty   (duty)
    );

    odiv_counter #(.W(CW)) u_cnt (
        .clk      (div_clk),
        .rst_n    (rst_n),
        .ratio_in (ratio),
        .hi_in    (hi_len),
        .duty_in  (duty),
        .hi_q     (hi_q),
        .duty_q   (duty_q)
    );

    odiv_out_stage u_out (
        .clk    (div_clk),
        .rst_n  (rst_n),
        .hi_q   (hi_q),
        .duty_q (duty_q),
        .en_in  (out_en),
        .out_p  (out_p),
        .out_n  (out_n)
    );
endmodule

// File: tb/coded_clk_divider_tb.sv
module coded_clk_divider_tb;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk_vco = 1'b0;
    logic       clk_ref = 1'b0;
    logic       use_ref = 1'b0;
    logic       rst_n   = 1'b0;
    logic [6:0] div_code = 7'd4;
    logic       out_en  = 1'b1;
    logic       out_p;
    logic       out_n;

    int n_chk = 0;
    int n_bad = 0;
    int n_cmp = 0;
    bit done  = 1'b0;

    coded_clk_divider u_dut (
        .clk_vco (clk_vco),
        .clk_ref (clk_ref),
        .use_ref (use_ref),
        .rst_n   (rst_n),
        .div_code(div_code),
        .out_en  (out_en),
        .out_p   (out_p),
        .out_n   (out_n)
    );

    always #5  clk_vco = ~clk_vco;   // 100 MHz
    always #13 clk_ref = ~clk_ref;   // reference, 26 ns period

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_ratio(input logic [6:0] c);
        if (c <= 7'd2) return 2;
        if (c <= 7'd5) return int'(c);
        return int'(c) & ~1;
    endfunction

    task automatic poll();
        #1;
        if (out_n === out_p) n_cmp++;
    endtask

    task automatic wait_rise(output bit got);
        logic prev;
        got  = 1'b0;
        prev = out_p;
        for (int i = 0; i < 6000; i++) begin
            poll();
            if (!prev && out_p) begin
                got = 1'b1;
                break;
            end
            prev = out_p;
        end
    endtask

    // Measure one full period from a rising edge (ns period, ns high).
    task automatic measure(output int per, output int hi);
        bit   got;
        logic prev;
        wait_rise(got);
        per = -1;
        hi  = -1;
        if (!got) return;
        per  = 0;
        hi   = 1;
        prev = 1'b1;
        for (int i = 0; i < 6000; i++) begin
            poll();
            per++;
            if (!prev && out_p) return;
            if (out_p) hi++;
            prev = out_p;
        end
        per = -1;
    endtask

    task automatic hold_reset(input logic src);
        rst_n   = 1'b0;
        use_ref = src;
        #300;
        chk(out_p == 1'b0, "R7", "out_p in reset", int'(out_p), 0);
        chk(out_n == 1'b1, "R7", "out_n in reset", int'(out_n), 1);
        rst_n = 1'b1;
    endtask

    // Check one code: period and high time against the computed ratio.
    task automatic t_code(input logic [6:0] code, input string req, input int unit);
        int p, h, n;
        div_code = code;
        measure(p, h);
        measure(p, h);
        n = exp_ratio(code);
        chk(p == n * unit, req, $sformatf("period code %0d", code), p, n * unit);
        chk(h == n * unit / 2, (n % 2 == 1) ? "R5" : "R4",
            $sformatf("high time code %0d", code), h, n * unit / 2);
    endtask

    task automatic t_reset_release();
        rst_n    = 1'b0;
        div_code = 7'd4;
        #100;
        @(posedge clk_vco);
        #2.5;
        rst_n = 1'b1;
        #7;
        chk(out_p == 1'b0, "R7", "out_p before first edge", int'(out_p), 0);
        #1;
        chk(out_p == 1'b1, "R7", "out_p after first edge", int'(out_p), 1);
    endtask

    task automatic t_mid_change();
        bit      got;
        int      p, h;
        realtime t0;
        div_code = 7'd10;
        measure(p, h);
        wait_rise(got);
        t0 = $realtime;
        #30;
        div_code = 7'd4;
        wait_rise(got);
        chk(int'($realtime - t0) == 100, "R6", "period holding mid change",
            int'($realtime - t0), 100);
        t0 = $realtime;
        wait_rise(got);
        chk(int'($realtime - t0) == 40, "R6", "period after mid change",
            int'($realtime - t0), 40);
    endtask

    task automatic t_late_change();
        bit      got;
        int      p, h;
        realtime t0;
        div_code = 7'd4;
        measure(p, h);
        wait_rise(got);
        t0 = $realtime;
        #39;
        div_code = 7'd6;
        wait_rise(got);
        chk(int'($realtime - t0) == 40, "R6", "period with late change",
            int'($realtime - t0), 40);
        t0 = $realtime;
        wait_rise(got);
        chk(int'($realtime - t0) == 60, "R6", "period after late change",
            int'($realtime - t0), 60);
    endtask

    task automatic t_disable();
        bit got;
        int bad;
        int p, h;
        div_code = 7'd4;
        measure(p, h);
        out_en = 1'b0;
        #20;
        bad = 0;
        for (int i = 0; i < 200; i++) begin
            poll();
            if (out_p !== 1'b0 || out_n !== 1'b1) bad++;
        end
        chk(bad == 0, "R8", "samples off parked polarity", bad, 0);
        out_en = 1'b1;
        measure(p, h);
        chk(p == 40, "R8", "period after re-enable", p, 40);
    endtask

    initial begin
        #0.5;
        hold_reset(1'b0);
        t_reset_release();

        t_code(7'd0, "R1", 10);
        t_code(7'd1, "R1", 10);
        t_code(7'd2, "R1", 10);
        t_code(7'd3, "R2", 10);
        t_code(7'd4, "R2", 10);
        t_code(7'd5, "R2", 10);
        t_code(7'd6, "R3", 10);
        t_code(7'd7, "R3", 10);
        t_code(7'd11, "R3", 10);
        t_code(7'd127, "R3", 10);

        t_mid_change();
        t_late_change();
        t_disable();

        chk(n_cmp == 0, "R9", "complement mismatches", n_cmp, 0);

        div_code = 7'd4;
        hold_reset(1'b1);
        t_code(7'd4, "R10", 26);
        t_code(7'd3, "R10", 26);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #3000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule